// File: doc/BRIEF.md
# Snoop Inquire Response Unit

This block answers snoop inquiries from other bus masters against the tags of a small direct-mapped data cache and a small direct-mapped instruction cache. An active-low strobe marks a valid snoop address. The unit reads both tag arrays in the clock after the strobe and compares in the clock after that. It then drives an active-low hit output. That output holds its value until the next inquiry completes.

When the inquiry lands on a modified line of the data cache, an active-low modified-hit output asserts in the same clock as the hit output. It stays asserted until the write-back logic returns a one-cycle done pulse, which keeps other masters off the line until the line is written back. While that hold is active, new strobes are refused and a sticky overrun flag records the refusal. Tags and line states are loaded through a fill port, and each cache has 16 lines.

Control lives in a two-state machine. `ST_OPEN` accepts strobes. It moves to `ST_HOLD` when a completing lookup hits a modified data line (transition *mod_hit*). `ST_HOLD` refuses strobes. It returns to `ST_OPEN` on a done pulse (transition *wb_release*), unless a lookup already in flight completes with another modified hit in that same cycle (transition *rehold*, which stays in `ST_HOLD`).

Top module: `snoop_resp_unit`

## Requirements
- R1: After reset, hit_n = 1, hitm_n = 1 and overrun = 0, and every line of both caches is invalid, so any inquiry misses.
- R2: A strobe (snp_strb_n = 0) sampled at clock edge E updates hit_n at edge E+2 and not before. A hit drives hit_n to 0.
- R3: An inquiry that misses both caches drives hit_n to 1 at edge E+2.
- R4: hit_n keeps its last value in every cycle in which no lookup completes.
- R5: A hit in the instruction cache alone asserts hit_n but never hitm_n. An instruction-cache fill written with state 2'b11 acts as valid-clean.
- R6: A hit on a data line in state 2'b11 (modified) drives hitm_n to 0 at the same edge that drives hit_n to 0.
- R7: hitm_n stays 0 until wb_done = 1 is sampled. It then returns to 1 at that same edge.
- R8: A strobe sampled while hitm_n = 0 is ignored: it never changes hit_n. It also sets overrun, which stays 1 until reset.
- R9: The snoop address splits into offset = addr[4:0] (ignored), index = addr[8:5] and tag = addr[31:9]. A hit needs a valid line at that index whose stored tag is equal to the tag.
- R10: The line state encoding is: bit 0 = valid and bit 1 = dirty, so 2'b00 is invalid, 2'b01 is valid-clean and 2'b11 is modified. 2'b10 counts as invalid.
- R11: The fill port (fill_we = 1, fill_icache = 0 for the data cache and 1 for the instruction cache) writes tag and state at fill_idx. A fill sampled at the same edge as a strobe is seen by that inquiry.
- R12: Strobes on consecutive cycles are pipelined. Each one produces its own result on hit_n two edges after it, in order.
- R13: A wb_done pulse while hitm_n = 1 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_strb_n | input | 1 | Active-low snoop address strobe |
| snp_addr | input | ADDR_W | Snoop address |
| fill_we | input | 1 | Tag/state write enable |
| fill_icache | input | 1 | Fill target: 0 = data cache, 1 = instruction cache |
| fill_idx | input | IDX_W | Line index to write |
| fill_tag | input | TAG_W | Tag to store |
| fill_state | input | 2 | Line state to store (bit 0 valid, bit 1 dirty) |
| wb_done | input | 1 | One-cycle pulse: modified line fully written back |
| hit_n | output | 1 | Active-low inquiry hit, held between inquiries |
| hitm_n | output | 1 | Active-low hit on a modified data line |
| overrun | output | 1 | Sticky flag: a strobe was refused during a write-back hold |

## Verification
The release of a write-back hold and a new strobe can meet in one cycle. The bench provokes this by raising wb_done and dropping snp_strb_n on the same cycle while hitm_n is low, using an address that would miss. It judges the result this way: hitm_n must rise at that edge, and hit_n must still show the earlier hit two edges later, because the strobe was refused. A second collision puts a fill write and a strobe to the same line in one cycle. There the lookup must already see the new tag.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_t;

    localparam logic [1:0] LS_INVALID  = 2'b00;
    localparam logic [1:0] LS_MODIFIED = 2'b11;

    function automatic logic line_valid(input logic [1:0] st);
        return st[0];
    endfunction

    function automatic logic line_dirty(input logic [1:0] st);
        return st == LS_MODIFIED;
    endfunction

endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
    import snp_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 23,
    parameter bit ALLOW_MOD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [1:0]       wr_state,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [1:0]       rd_state
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [1:0]       st_q  [DEPTH];
    logic [1:0]       st_in;

    generate
        if (ALLOW_MOD) begin : g_full_state
            assign st_in = wr_state;
        end else begin : g_valid_only
            logic unused_dirty;
            assign unused_dirty = wr_state[1];
            assign st_in = {1'b0, wr_state[0]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= LS_INVALID;
        end else if (wr_en) begin
            st_q[wr_idx] <= st_in;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_state <= LS_INVALID;
            rd_tag   <= '0;
        end else if (rd_en) begin
            rd_state <= st_q[rd_idx];
            rd_tag   <= tag_q[rd_idx];
        end
    end

    generate
        if (!ALLOW_MOD) begin : g_chk_clean
            // R5: a valid-only array never reports a dirty line
            a_r5_no_dirty_read: assert property (@(posedge clk) disable iff (!rst_n)
                !line_dirty(rd_state));
        end
    endgenerate

endmodule

// File: rtl/snp_lookup.sv
module snp_lookup
    import snp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              admit,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              fill_we,
    input  logic              fill_icache,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [1:0]        fill_state,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_mod
);
    localparam int NCACHE = 2;

    logic              s1_valid, s2_valid;
    logic [IDX_W-1:0]  s1_idx;
    logic [TAG_W-1:0]  s1_tag, s2_tag;
    logic [TAG_W-1:0]  rd_tag [NCACHE];
    logic [1:0]        rd_st  [NCACHE];
    logic [NCACHE-1:0] way_hit;
    logic              unused_ofs;

    assign unused_ofs = ^snp_addr[OFS_W-1:0];

    // stage 1: capture the split address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_tag   <= '0;
        end else begin
            s1_valid <= admit;
            if (admit) begin
                s1_idx <= snp_addr[OFS_W +: IDX_W];
                s1_tag <= snp_addr[ADDR_W-1 -: TAG_W];
            end
        end
    end

    // stage 2: tag read (inside the arrays), tag carried along
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_tag   <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) s2_tag <= s1_tag;
        end
    end

    generate
        for (genvar c = 0; c < NCACHE; c++) begin : g_cache
            snp_tag_array #(
                .IDX_W    (IDX_W),
                .TAG_W    (TAG_W),
                .ALLOW_MOD(c == 0)
            ) u_arr (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (fill_we && (fill_icache == (c == 1))),
                .wr_idx  (fill_idx),
                .wr_tag  (fill_tag),
                .wr_state(fill_state),
                .rd_en   (s1_valid),
                .rd_idx  (s1_idx),
                .rd_tag  (rd_tag[c]),
                .rd_state(rd_st[c])
            );
            assign way_hit[c] = s2_valid && line_valid(rd_st[c]) && (rd_tag[c] == s2_tag);
        end
    endgenerate

    assign res_valid = s2_valid;
    assign res_hit   = |way_hit;
    assign res_mod   = way_hit[0] && line_dirty(rd_st[0]);

    // R12: every admitted strobe advances one stage per clock
    a_r12_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
        admit |=> s1_valid);
    a_r12_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> res_valid);

endmodule

// File: rtl/snp_hold_fsm.sv
module snp_hold_fsm
    import snp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic res_valid,
    input  logic res_mod,
    input  logic wb_done,
    output logic admit,
    output logic hitm_n,
    output logic overrun
);
    hold_st_t state_q, state_d;
    logic     mod_hit;

    assign mod_hit = res_valid && res_mod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (mod_hit)                state_d = ST_HOLD;
            ST_HOLD: if (wb_done && !mod_hit)    state_d = ST_OPEN;
            default:                             state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        hitm_n = (state_q != ST_HOLD);
        admit  = strobe && (state_q == ST_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               overrun <= 1'b0;
        else if (strobe && state_q == ST_HOLD)    overrun <= 1'b1;
    end

    // R7: the hold persists until a done pulse arrives
    a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!hitm_n && !wb_done) |=> !hitm_n);
    // R8: overrun is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/snoop_resp_unit.sv
module snoop_resp_unit
    import snp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_strb_n,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              fill_we,
    input  logic              fill_icache,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [1:0]        fill_state,
    input  logic              wb_done,
    output logic              hit_n,
    output logic              hitm_n,
    output logic              overrun
);
    logic admit, res_valid, res_hit, res_mod;

    snp_hold_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (!snp_strb_n),
        .res_valid(res_valid),
        .res_mod  (res_mod),
        .wb_done  (wb_done),
        .admit    (admit),
        .hitm_n   (hitm_n),
        .overrun  (overrun)
    );

    snp_lookup #(
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W),
        .IDX_W (IDX_W)
    ) u_look (
        .clk        (clk),
        .rst_n      (rst_n),
        .admit      (admit),
        .snp_addr   (snp_addr),
        .fill_we    (fill_we),
        .fill_icache(fill_icache),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_state (fill_state),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_mod    (res_mod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hit_n <= 1'b1;
        else if (res_valid) hit_n <= !res_hit;
    end

    // R4: hit_n moves only when a lookup completes
    a_r4_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hit_n));
    // R6: modified-hit never asserts without the hit output
    a_r6_hitm_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hitm_n) |-> !hit_n);
    // R8: a strobe during the hold is recorded
    a_r8_refused_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!hitm_n && !snp_strb_n) |=> overrun);
    // R13: a done pulse outside a hold leaves hitm_n high
    a_r13_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (hitm_n && wb_done && !(res_valid && res_mod)) |=> hitm_n);

endmodule

// File: tb/test_snoop_resp_unit.sv
module test_snoop_resp_unit;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snp_strb_n = 1'b1;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              fill_we = 1'b0;
    logic              fill_icache = 1'b0;
    logic [3:0]        fill_idx = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [1:0]        fill_state = '0;
    logic              wb_done = 1'b0;
    logic              hit_n, hitm_n, overrun;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    snoop_resp_unit i_snoop_resp_unit (
        .clk(clk), .rst_n(rst_n), .snp_strb_n(snp_strb_n), .snp_addr(snp_addr),
        .fill_we(fill_we), .fill_icache(fill_icache), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .fill_state(fill_state), .wb_done(wb_done),
        .hit_n(hit_n), .hitm_n(hitm_n), .overrun(overrun)
    );

    function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t,
                                             input logic [3:0] i, input logic [4:0] o);
        return {t, i, o};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic fill(input logic ic, input logic [3:0] idx,
                        input logic [TAG_W-1:0] t, input logic [1:0] st);
        fill_we = 1'b1; fill_icache = ic; fill_idx = idx; fill_tag = t; fill_state = st;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    // strobe for one edge, return after edge E+2
    task automatic inquire(input logic [ADDR_W-1:0] a);
        snp_addr = a; snp_strb_n = 1'b0;
        @(negedge clk);
        snp_strb_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 hit_n", hit_n, 1'b1);
        chk("R1 hitm_n", hitm_n, 1'b1);
        chk("R1 overrun", overrun, 1'b0);
        inquire(mk(23'h0, 4'd0, 5'd0));
        chk("R1 empty miss", hit_n, 1'b1);
    endtask

    task automatic t_clean_hit;
        fill(1'b0, 4'd3, 23'h123, 2'b01);
        snp_addr = mk(23'h123, 4'd3, 5'd0); snp_strb_n = 1'b0;
        @(negedge clk); snp_strb_n = 1'b1;
        @(negedge clk);
        chk("R2 not at E+1", hit_n, 1'b1);
        @(negedge clk);
        chk("R2 hit at E+2", hit_n, 1'b0);
        chk("R10 clean no hitm", hitm_n, 1'b1);
        repeat (5) @(negedge clk);
        chk("R4 held", hit_n, 1'b0);
        inquire(mk(23'h124, 4'd3, 5'd0));
        chk("R9 tag mismatch", hit_n, 1'b1);
        chk("R3 miss", hit_n, 1'b1);
        inquire(mk(23'h123, 4'd3, 5'd31));
        chk("R9 offset ignored", hit_n, 1'b0);
    endtask

    task automatic t_icache;
        fill(1'b1, 4'd7, 23'h55, 2'b11);
        inquire(mk(23'h0, 4'd0, 5'd0));
        chk("R3 reset hit", hit_n, 1'b1);
        inquire(mk(23'h55, 4'd7, 5'd4));
        chk("R5 icache hit", hit_n, 1'b0);
        chk("R5 icache no hitm", hitm_n, 1'b1);
        fill(1'b0, 4'd8, 23'h66, 2'b10);
        inquire(mk(23'h66, 4'd8, 5'd0));
        chk("R10 state 10 invalid", hit_n, 1'b1);
    endtask

    task automatic t_modified;
        fill(1'b0, 4'd9, 23'h7a, 2'b11);
        snp_addr = mk(23'h7a, 4'd9, 5'd0); snp_strb_n = 1'b0;
        @(negedge clk); snp_strb_n = 1'b1;
        @(negedge clk);
        chk("R6 hitm not at E+1", hitm_n, 1'b1);
        @(negedge clk);
        chk("R6 hit", hit_n, 1'b0);
        chk("R6 hitm same edge", hitm_n, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 hold", hitm_n, 1'b0);
        inquire(mk(23'h1, 4'd1, 5'd0));
        chk("R8 refused keeps hit", hit_n, 1'b0);
        chk("R8 overrun set", overrun, 1'b1);
        wb_done = 1'b1;
        @(negedge clk); wb_done = 1'b0;
        chk("R7 release", hitm_n, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 overrun sticky", overrun, 1'b1);
    endtask

    task automatic t_idle_done;
        wb_done = 1'b1;
        @(negedge clk); wb_done = 1'b0;
        chk("R13 hitm", hitm_n, 1'b1);
        chk("R13 hit", hit_n, 1'b0);
    endtask

    task automatic t_collision;
        inquire(mk(23'h7a, 4'd9, 5'd0));
        chk("R6 rehold", hitm_n, 1'b0);
        snp_addr = mk(23'h2, 4'd2, 5'd0); snp_strb_n = 1'b0; wb_done = 1'b1;
        @(negedge clk); snp_strb_n = 1'b1; wb_done = 1'b0;
        chk("R7 release with strobe", hitm_n, 1'b1);
        repeat (2) @(negedge clk);
        chk("R8 colliding strobe ignored", hit_n, 1'b0);
    endtask

    task automatic t_back_to_back;
        snp_strb_n = 1'b0;
        snp_addr = mk(23'h3, 4'd5, 5'd0);
        @(negedge clk); snp_addr = mk(23'h123, 4'd3, 5'd0);
        @(negedge clk); snp_addr = mk(23'h4, 4'd6, 5'd0);
        @(negedge clk); snp_strb_n = 1'b1;
        chk("R12 first miss", hit_n, 1'b1);
        @(negedge clk);
        chk("R12 second hit", hit_n, 1'b0);
        @(negedge clk);
        chk("R12 third miss", hit_n, 1'b1);
    endtask

    task automatic t_fill_same_edge;
        fill_we = 1'b1; fill_icache = 1'b0; fill_idx = 4'd12;
        fill_tag = 23'h3ab; fill_state = 2'b01;
        snp_addr = mk(23'h3ab, 4'd12, 5'd0); snp_strb_n = 1'b0;
        @(negedge clk);
        fill_we = 1'b0; snp_strb_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 fill seen", hit_n, 1'b0);
        chk("R11 no hitm", hitm_n, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_hit();
        t_icache();
        t_modified();
        t_idle_done();
        t_collision();
        t_back_to_back();
        t_fill_same_edge();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule